// File: doc/BRIEF.md
# Interval, Periodic and Watchdog Timer Unit

This block provides three timers that share one tick input and one small register port. A programmable down-counter signals when a loaded count runs out and may reload itself. A periodic timer fires every 2^n ticks, where software picks n from four choices. A watchdog escalates each time its period runs out: the first expiry arms it, the second raises an interrupt, and the third requests a reset of a type chosen by software. A tick is one clock cycle with `tick` high. When `tick` is low, all counters hold their values.

Software reaches four word registers through a two-bit address: control (0), status (1), interval reload (2) and interval current count (3, read-only). Status flags are cleared by writing ones to them. The three interrupt outputs are levels: each is high while its status flag is set and its enable bit is set. The reset request pulses for one cycle and carries the reset-type code.

Top module: `tmr_unit`

## Requirements
- R1: After reset, every register reads 0, all interrupt lines are low and `rstReq` is 0. The control register keeps only bits 31:22, and the status register holds only bits 31:26. All other bits read 0.
- R2: A write to address 2 sets both the reload value and the current count. While running, each tick lowers the count by one. On the tick that ends a count of 1, status bit 27 sets, so a load of N expires after N ticks. `pitIrq` is high while status bit 27 and control bit 26 are both set.
- R3: The interval count holds and never expires while control bit 26 is clear or while the reload value is 0 or 1.
- R4: On expiry with control bit 22 set, the count restarts from the reload value. With bit 22 clear, the count goes to 0 and stays there.
- R5: The periodic timer expires on every global tick whose number (counted from 1 after reset) is a multiple of 2^(FIT_BASE + STEP*s), where s is control bits 25:24. Each expiry sets status bit 26. `fitIrq` is high while status bit 26 and control bit 23 are both set.
- R6: The watchdog expires on global tick numbers that are multiples of 2^(WDT_BASE + STEP*w), where w is control bits 31:30. An expiry with status bit 31 clear sets bit 31 and raises no interrupt.
- R7: An expiry with status bit 31 set and bit 30 clear sets bit 30. `wdtIrq` is high while status bit 30 and control bit 27 are both set.
- R8: An expiry with status bits 31 and 30 both set copies control bits 29:28 into status bits 29:28. In the next cycle, `rstReq` carries that code for exactly one cycle. Code 1 requests a core reset, 2 a chip reset and 3 a system reset. Code 0 means no action, and `rstReq` stays 0.
- R9: Writing to address 1 clears each status bit that is written as 1 and leaves bits written as 0 unchanged. If a hardware event sets a bit in the same cycle it is cleared, the bit ends up set.
- R10: While `tick` is low, no counter advances and no timer expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase advance enable, one tick per cycle |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 control, 1 status, 2 reload, 3 count |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr` (combinational) |
| pitIrq | output | 1 | Interval timer interrupt level |
| fitIrq | output | 1 | Periodic timer interrupt level |
| wdtIrq | output | 1 | Watchdog interrupt level |
| rstReq | output | 2 | One-cycle reset request carrying the reset-type code |

## Verification
The risky overlap is a software write-one-to-clear of a status flag landing in the same cycle as the hardware expiry that sets that flag. The bench provokes this by computing, from its own count of ticks, the exact tick on which the periodic timer wraps. It then issues the clearing write together with that tick and expects the flag to remain set. A plain clear in a quiet cycle must still take effect. A second overlap is a watchdog expiry that coincides with the status bits it reads. The bench judges this by checking, at each expiry, that the stage advances only from the stage recorded before that expiry.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    ADDR_CTL    = 2'd0,
    ADDR_STAT   = 2'd1,
    ADDR_RELOAD = 2'd2,
    ADDR_COUNT  = 2'd3
  } tmr_addr_e;

  // control bit positions
  localparam int C_WDT_SEL_HI = 31;
  localparam int C_WDT_SEL_LO = 30;
  localparam int C_RST_HI     = 29;
  localparam int C_RST_LO     = 28;
  localparam int C_WDT_IE     = 27;
  localparam int C_PIT_IE     = 26;
  localparam int C_FIT_SEL_HI = 25;
  localparam int C_FIT_SEL_LO = 24;
  localparam int C_FIT_IE     = 23;
  localparam int C_PIT_AUTO   = 22;

  // status bit positions
  localparam int S_WDT_ARM  = 31;
  localparam int S_WDT_WARN = 30;
  localparam int S_RST_HI   = 29;
  localparam int S_RST_LO   = 28;
  localparam int S_PIT      = 27;
  localparam int S_FIT      = 26;

  localparam logic [REG_W-1:0] CTL_MASK  = 32'hFFC0_0000;
  localparam logic [REG_W-1:0] STAT_MASK = 32'hFC00_0000;

  // strobes from control to datapath
  typedef struct packed {
    logic       tick;
    logic       loadPit;
    logic       pitEnable;
    logic       autoReload;
    logic [1:0] fitSel;
    logic [1:0] wdtSel;
  } tmr_strobe_t;

  // expiry events from datapath to control
  typedef struct packed {
    logic pitExp;
    logic fitExp;
    logic wdtExp;
  } tmr_event_t;
endpackage

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int FIT_BASE = 9,
  parameter int WDT_BASE = 17,
  parameter int STEP     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmr_strobe_t       strobe,
  input  logic [REG_W-1:0]  loadValue,
  output tmr_event_t        events,
  output logic [REG_W-1:0]  reloadVal,
  output logic [REG_W-1:0]  pitCount
);
  localparam int NUM_SEL = 4;
  localparam int TB_W    = WDT_BASE + STEP * (NUM_SEL - 1);

  logic [TB_W-1:0]    tbCnt;
  logic [NUM_SEL-1:0] fitHit;
  logic [NUM_SEL-1:0] wdtHit;

  // shared free-running timebase
  always_ff @(posedge clk) begin
    if (!rstN) tbCnt <= '0;
    else if (strobe.tick) tbCnt <= tbCnt + 1'b1;
  end

  // period taps: a period of 2^n ends when the low n bits are all ones
  for (genvar i = 0; i < NUM_SEL; i++) begin : g_taps
    assign fitHit[i] = &tbCnt[FIT_BASE + STEP*i - 1 : 0];
    assign wdtHit[i] = &tbCnt[WDT_BASE + STEP*i - 1 : 0];
  end

  assign events.fitExp = strobe.tick & fitHit[strobe.fitSel];
  assign events.wdtExp = strobe.tick & wdtHit[strobe.wdtSel];

  // programmable interval down-counter
  logic pitRun;
  assign pitRun = strobe.tick && strobe.pitEnable && (reloadVal > 1) && (pitCount != '0);
  assign events.pitExp = pitRun && (pitCount == 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadVal <= '0;
      pitCount  <= '0;
    end else if (strobe.loadPit) begin
      reloadVal <= loadValue;
      pitCount  <= loadValue;
    end else if (pitRun) begin
      if (pitCount == 1) pitCount <= strobe.autoReload ? reloadVal : '0;
      else               pitCount <= pitCount - 1'b1;
    end
  end
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [1:0]        addr,
  input  logic [REG_W-1:0]  wrData,
  input  tmr_event_t        events,
  output tmr_strobe_t       strobe,
  output logic [REG_W-1:0]  ctlReg,
  output logic [REG_W-1:0]  statReg,
  output logic              pitIrq,
  output logic              fitIrq,
  output logic              wdtIrq,
  output logic [1:0]        rstReq
);
  logic             wrCtl;
  logic             wrStat;
  logic [REG_W-1:0] statNext;
  logic             rstFire;

  assign wrCtl  = wrEn && (addr == ADDR_CTL);
  assign wrStat = wrEn && (addr == ADDR_STAT);

  always_comb begin
    statNext = statReg;
    rstFire  = 1'b0;
    if (wrStat) statNext = statNext & ~(wrData & STAT_MASK);
    if (events.pitExp) statNext[S_PIT] = 1'b1;
    if (events.fitExp) statNext[S_FIT] = 1'b1;
    if (events.wdtExp) begin
      if (!statReg[S_WDT_ARM]) begin
        statNext[S_WDT_ARM] = 1'b1;
      end else if (!statReg[S_WDT_WARN]) begin
        statNext[S_WDT_WARN] = 1'b1;
      end else begin
        statNext[S_RST_HI:S_RST_LO] = ctlReg[C_RST_HI:C_RST_LO];
        rstFire = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlReg  <= '0;
      statReg <= '0;
      rstReq  <= '0;
    end else begin
      if (wrCtl) ctlReg <= wrData & CTL_MASK;
      statReg <= statNext;
      rstReq  <= rstFire ? ctlReg[C_RST_HI:C_RST_LO] : 2'd0;
    end
  end

  always_comb begin
    strobe.tick       = tick;
    strobe.loadPit    = wrEn && (addr == ADDR_RELOAD);
    strobe.pitEnable  = ctlReg[C_PIT_IE];
    strobe.autoReload = ctlReg[C_PIT_AUTO];
    strobe.fitSel     = ctlReg[C_FIT_SEL_HI:C_FIT_SEL_LO];
    strobe.wdtSel     = ctlReg[C_WDT_SEL_HI:C_WDT_SEL_LO];
  end

  assign pitIrq = statReg[S_PIT]      & ctlReg[C_PIT_IE];
  assign fitIrq = statReg[S_FIT]      & ctlReg[C_FIT_IE];
  assign wdtIrq = statReg[S_WDT_WARN] & ctlReg[C_WDT_IE];
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int FIT_BASE = 9,
  parameter int WDT_BASE = 17,
  parameter int STEP     = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic        wrEn,
  input  logic [1:0]  addr,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        pitIrq,
  output logic        fitIrq,
  output logic        wdtIrq,
  output logic [1:0]  rstReq
);
  tmr_strobe_t      strobe;
  tmr_event_t       events;
  logic [REG_W-1:0] ctlReg;
  logic [REG_W-1:0] statReg;
  logic [REG_W-1:0] reloadVal;
  logic [REG_W-1:0] pitCount;

  tmr_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .events(events), .strobe(strobe),
    .ctlReg(ctlReg), .statReg(statReg),
    .pitIrq(pitIrq), .fitIrq(fitIrq), .wdtIrq(wdtIrq), .rstReq(rstReq)
  );

  tmr_datapath #(.FIT_BASE(FIT_BASE), .WDT_BASE(WDT_BASE), .STEP(STEP)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadValue(wrData),
    .events(events), .reloadVal(reloadVal), .pitCount(pitCount)
  );

  always_comb begin
    unique case (addr)
      ADDR_CTL:    rdData = ctlReg;
      ADDR_STAT:   rdData = statReg;
      ADDR_RELOAD: rdData = reloadVal;
      default:     rdData = pitCount;
    endcase
  end
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk (
  input logic        clk,
  input logic        rstN,
  input logic        tick,
  input logic        wrEn,
  input logic [1:0]  addr,
  input logic        pitEn,
  input logic        wdtArm,
  input logic        wdtWarn,
  input logic        pitFlag,
  input logic [31:0] pitCount,
  input logic [1:0]  rstReq
);
  // R3: a disabled interval timer keeps its count
  a_r3_pit_disabled_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!pitEn && !(wrEn && addr == 2'd2)) |=> $stable(pitCount));

  // R10: no tick, no count change
  a_r10_no_tick_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !(wrEn && addr == 2'd2)) |=> $stable(pitCount));

  // R2: the interval flag only rises on a tick
  a_r2_flag_needs_tick: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pitFlag) |-> $past(tick));

  // R7: second stage only after the first
  a_r7_warn_after_arm: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdtWarn) |-> $past(wdtArm));

  // R8: reset request lasts one cycle
  a_r8_rst_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (rstReq != 2'd0) |=> (rstReq == 2'd0));

  // R8: reset only from the third stage
  a_r8_rst_from_stage3: assert property (@(posedge clk) disable iff (!rstN)
    (rstReq != 2'd0) |-> $past(wdtArm && wdtWarn));
endmodule

bind tmr_unit tmr_unit_chk chk_i (
  .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .addr(addr),
  .pitEn(ctlReg[26]), .wdtArm(statReg[31]), .wdtWarn(statReg[30]),
  .pitFlag(statReg[27]), .pitCount(pitCount), .rstReq(rstReq)
);

// File: tb/tmr_unit_tb_top.sv
`timescale 1ns/1ps
module tmr_unit_tb_top;
  localparam int FB = 2, WB = 3, ST = 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        pitIrq, fitIrq, wdtIrq;
  logic [1:0]  rstReq;

  int nChecks = 0;
  int nFails  = 0;
  int tbCount = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  tmr_unit #(.FIT_BASE(FB), .WDT_BASE(WB), .STEP(ST)) dut_i (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .pitIrq(pitIrq), .fitIrq(fitIrq),
    .wdtIrq(wdtIrq), .rstReq(rstReq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; #1 v = rdData;
  endtask

  task automatic runTicks(int n);
    if (n > 0) begin
      @(negedge clk); tick = 1'b1;
      repeat (n) @(posedge clk);
      @(negedge clk); tick = 1'b0;
      tbCount += n;
    end
  endtask

  function automatic int untilNext(int p);
    return (tbCount / p + 1) * p - tbCount;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v, s0;
    int d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state and register masks
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v); check("R1 reg after reset", v, 32'h0);
    end
    check("R1 irqs", {29'd0, pitIrq, fitIrq, wdtIrq}, 32'h0);
    check("R1 rstReq", {30'd0, rstReq}, 32'h0);
    wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, v); check("R1 ctl mask", v, 32'hFFC0_0000);
    wr(2'd0, 32'h0);

    // R3 disabled by control bit 26 clear, then by reload value 1
    wr(2'd2, 32'd5); runTicks(10);
    rd(2'd3, v); check("R3 ctl26 clear count", v, 32'd5);
    rd(2'd1, v); check("R3 ctl26 clear no flag", v[27], 1'b0);
    wr(2'd0, 32'h0400_0000); wr(2'd2, 32'd1); runTicks(5);
    rd(2'd3, v); check("R3 reload 1 count", v, 32'd1);
    rd(2'd1, v); check("R3 reload 1 no flag", v[27], 1'b0);
    wr(2'd2, 32'd0); runTicks(3);
    rd(2'd3, v); check("R3 reload 0 count", v, 32'd0);

    // R2 one-shot expiry, R4 stop
    wr(2'd2, 32'd6); runTicks(5);
    rd(2'd3, v); check("R2 count before expiry", v, 32'd1);
    rd(2'd1, v); check("R2 flag before expiry", v[27], 1'b0);
    check("R2 irq before expiry", pitIrq, 1'b0);
    runTicks(1);
    rd(2'd1, v); check("R2 flag at expiry", v[27], 1'b1);
    check("R2 irq at expiry", pitIrq, 1'b1);
    runTicks(3);
    rd(2'd3, v); check("R4 stopped at zero", v, 32'd0);

    // R9 write-one clears, write zero leaves
    rd(2'd1, s0);
    wr(2'd1, 32'h0);
    rd(2'd1, v); check("R9 zero write no effect", v, s0);
    wr(2'd1, 32'h0800_0000);
    rd(2'd1, v); check("R9 bit27 cleared", v[27], 1'b0);
    check("R9 irq dropped", pitIrq, 1'b0);

    // R4 auto-reload sweep over reload values
    wr(2'd0, 32'h0440_0000);
    for (int r = 2; r < 10; r++) begin
      wr(2'd2, r); wr(2'd1, 32'h0800_0000);
      runTicks(r - 1);
      rd(2'd1, v); check("R4 no flag before wrap", v[27], 1'b0);
      runTicks(1);
      rd(2'd1, v); check("R4 flag at wrap", v[27], 1'b1);
      rd(2'd3, v); check("R4 reloaded count", v, r);
    end

    // R10 tick low freezes everything
    wr(2'd2, 32'd7); runTicks(2);
    rd(2'd1, s0);
    repeat (20) @(negedge clk);
    rd(2'd3, v); check("R10 count frozen", v, 32'd5);
    rd(2'd1, v); check("R10 status frozen", v, s0);

    // R5 periodic timer, every period select
    for (int sel = 0; sel < 4; sel++) begin
      wr(2'd0, (sel << 24) | 32'h0080_0000);
      wr(2'd1, 32'h0400_0000);
      d = untilNext(4 << sel);
      runTicks(d - 1);
      rd(2'd1, v); check("R5 no flag before period", v[26], 1'b0);
      check("R5 irq low before period", fitIrq, 1'b0);
      runTicks(1);
      rd(2'd1, v); check("R5 flag at period", v[26], 1'b1);
      check("R5 irq at period", fitIrq, 1'b1);
    end
    wr(2'd0, 32'h0); wr(2'd1, 32'h0400_0000);
    runTicks(untilNext(4));
    rd(2'd1, v); check("R5 flag with irq disabled", v[26], 1'b1);
    check("R5 irq masked", fitIrq, 1'b0);

    // R9 collision: clear and set of bit 26 in one cycle
    wr(2'd1, 32'h0400_0000);
    d = untilNext(4);
    runTicks(d - 1);
    @(negedge clk); tick = 1'b1; wrEn = 1'b1; addr = 2'd1; wrData = 32'h0400_0000;
    @(negedge clk); tick = 1'b0; wrEn = 1'b0;
    tbCount += 1;
    rd(2'd1, v); check("R9 set wins over clear", v[26], 1'b1);
    wr(2'd1, 32'h0400_0000);
    rd(2'd1, v); check("R9 quiet clear", v[26], 1'b0);

    // R6 R7 R8 watchdog stages, period 8, reset code 2
    wr(2'd0, 32'h2800_0000);
    wr(2'd1, 32'hFC00_0000);
    d = untilNext(8);
    runTicks(d - 1);
    rd(2'd1, v); check("R6 not armed yet", v[31], 1'b0);
    runTicks(1);
    rd(2'd1, v); check("R6 armed", v[31:30], 2'b10);
    check("R6 no irq", wdtIrq, 1'b0);
    runTicks(7);
    rd(2'd1, v); check("R7 warn not yet", v[30], 1'b0);
    runTicks(1);
    rd(2'd1, v); check("R7 warn set", v[30], 1'b1);
    check("R7 irq", wdtIrq, 1'b1);
    check("R7 no reset yet", rstReq, 2'd0);
    runTicks(7);
    check("R8 no reset before third", rstReq, 2'd0);
    runTicks(1);
    check("R8 reset code 2", rstReq, 2'd2);
    rd(2'd1, v); check("R8 status code 2", v[29:28], 2'd2);
    check("R8 pulse ended", rstReq, 2'd0);

    // R8 code 0: no request
    wr(2'd0, 32'h0800_0000);
    wr(2'd1, 32'h3000_0000);
    runTicks(untilNext(8));
    check("R8 code 0 no request", rstReq, 2'd0);
    rd(2'd1, v); check("R8 code 0 status", v[31:28], 4'hC);

    // R8 code 3 with period select 1 (16 ticks)
    wr(2'd0, 32'h7000_0000);
    runTicks(untilNext(16));
    check("R8 code 3 request", rstReq, 2'd3);
    rd(2'd1, v); check("R8 status code 3", v[29:28], 2'd3);

    done = 1;
    summary();
    $finish;
  end
endmodule